// File: doc/BRIEF.md
# Auto-Reload Timer with Overflow-Clocked PWM

This block is a free-running up-counter with a software-loaded start value. A write stores the start value and puts it straight into the count. After that, the count rises by one on every enabled tick. When a tick arrives while the count is at its all-ones value, the count wraps back to the stored start value. This emits a one-cycle overflow pulse and latches an interrupt request.

The count tick combines two inputs. A slow tick strobe provides the ticks, and a fast-source enable level acts as a gate: ticks only count while the gate level is high.

Every overflow also advances a 4-bit phase counter. The PWM pin is high while the phase is below a 4-bit duty setting. This gives a duty of K/16 over a frame of 16 overflow periods.

The interrupt request is kept by a two-state machine with the states `IRQ_IDLE` and `IRQ_PENDING`. It uses these transitions:
- **raise**: `IRQ_IDLE` to `IRQ_PENDING`, on a wrap.
- **hold**: `IRQ_PENDING` stays in `IRQ_PENDING` while there is no clear strobe, or while a wrap arrives together with the clear.
- **clear**: `IRQ_PENDING` to `IRQ_IDLE`, on the clear strobe with no wrap in the same cycle.
- **idle**: `IRQ_IDLE` stays in `IRQ_IDLE` when there is no wrap.

Top module: `reload_pwm_timer`

## Requirements
- R1: After a write of value N, each enabled tick raises `count_q` by exactly one, so after k ticks (with no wrap) it reads N+k.
- R2: A tick taken while `count_q` is 0xFFFF loads the stored start value into `count_q`. `ovf_pulse` is high for the one cycle following that clock edge and is low otherwise.
- R3: A tick is enabled only when `src_b_tick` and `src_a_en` are both 1 in the same cycle. With either of them at 0, `count_q` holds its value.
- R4: `irq` goes to 1 in the cycle after a wrap and stays at 1 until an `irq_clr` strobe. A clear that coincides with a wrap leaves `irq` at 1.
- R5: The PWM phase starts at 0 and advances by one (mod 16) per wrap. `pwm_out` is 1 exactly while the phase is below `duty_sel`, so a setting of 0 keeps it low and a setting of K gives K high periods per 16 wraps.
- R6: A write (`data_wr`=1) makes `count_q` equal to `data_wdata` on the next cycle, takes priority over a tick in the same cycle, and never causes a wrap.
- R7: After reset, `count_q` is 0, the stored start value is 0, the phase is 0, and `irq`, `ovf_pulse` and `pwm_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_en | input | 1 | Gate level for ticks (1 passes, 0 halts) |
| src_b_tick | input | 1 | Count tick strobe |
| data_wr | input | 1 | Write strobe for start value and count |
| data_wdata | input | 16 | Start value to load |
| duty_sel | input | 4 | PWM high time in overflow periods |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt |
| count_q | output | 16 | Live count |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| irq | output | 1 | Latched interrupt request |
| pwm_out | output | 1 | PWM output |

## Verification
A corrupted count or start value shows up on `count_q` in the very next sampled cycle, and a wrong wrap value shows up one cycle after the wrap. A phase counter that is off by even one step changes `pwm_out` within at most 16 overflows. The exhaustive sweep of all 16 duty settings over a full frame exposes this, because in that sweep every tick is a wrap. An interrupt state machine that drops or keeps its state wrongly becomes visible on `irq` one cycle after the clear strobe or after the wrap.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_t;
endpackage

// File: rtl/tick_gate.sv
module tick_gate (
    input  logic gate_lvl,
    input  logic tick_in,
    output logic tick_out
);
    always_comb tick_out = gate_lvl & tick_in;
endmodule

// File: rtl/reload_counter.sv
module reload_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             ovf_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] reload_q;

    always_comb wrap = tick && !wr && (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            reload_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            ovf_q <= wrap;
            if (wr) begin
                reload_q <= wdata;
                count    <= wdata;
            end else if (wrap) begin
                count <= reload_q;
            end else if (tick) begin
                count <= count + CNT_ONE;
            end
        end
    end

    assert_wrap_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == reload_q));
    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr) |=> $stable(count));
    assert_write_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (count == $past(wdata) && !ovf_q));
endmodule

// File: rtl/pwm_phase.sv
module pwm_phase #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [PH_W-1:0] duty,
    output logic            pwm
);
    localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else if (step) phase_q <= phase_q + PH_ONE;
    end

    always_comb pwm = (phase_q < duty);

    assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (phase_q == $past(phase_q) + PH_ONE));
    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(phase_q));
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clr,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (raise) state_d = IRQ_PENDING;
            IRQ_PENDING: if (clr && !raise) state_d = IRQ_IDLE;
            default:     state_d = IRQ_IDLE;
        endcase
    end

    always_comb irq = (state_q == IRQ_PENDING);

    assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);
    assert_irq_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> irq);
endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer #(
    parameter int CNT_W  = 16,
    parameter int DUTY_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_a_en,
    input  logic              src_b_tick,
    input  logic              data_wr,
    input  logic [CNT_W-1:0]  data_wdata,
    input  logic [DUTY_W-1:0] duty_sel,
    input  logic              irq_clr,
    output logic [CNT_W-1:0]  count_q,
    output logic              ovf_pulse,
    output logic              irq,
    output logic              pwm_out
);
    logic tick_en;
    logic wrap_now;

    tick_gate u_gate (
        .gate_lvl (src_a_en),
        .tick_in  (src_b_tick),
        .tick_out (tick_en)
    );

    reload_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .wr    (data_wr),
        .wdata (data_wdata),
        .count (count_q),
        .wrap  (wrap_now),
        .ovf_q (ovf_pulse)
    );

    pwm_phase #(.PH_W(DUTY_W)) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (wrap_now),
        .duty  (duty_sel),
        .pwm   (pwm_out)
    );

    irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (wrap_now),
        .clr   (irq_clr),
        .irq   (irq)
    );

    assert_ovf_follows_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> irq);
endmodule

// File: tb/tb_reload_pwm_timer.sv
module tb_reload_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_a_en = 1'b0;
    logic        src_b_tick = 1'b0;
    logic        data_wr = 1'b0;
    logic [15:0] data_wdata = '0;
    logic [3:0]  duty_sel = '0;
    logic        irq_clr = 1'b0;
    logic [15:0] count_q;
    logic        ovf_pulse, irq, pwm_out;

    int vectors = 0;
    int misses = 0;
    int novf = 0;
    bit done = 0;

    always #10 clk = ~clk;

    reload_pwm_timer dut (
        .clk(clk), .rst_n(rst_n), .src_a_en(src_a_en), .src_b_tick(src_b_tick),
        .data_wr(data_wr), .data_wdata(data_wdata), .duty_sel(duty_sel),
        .irq_clr(irq_clr), .count_q(count_q), .ovf_pulse(ovf_pulse),
        .irq(irq), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [15:0] v);
        data_wr = 1'b1; data_wdata = v;
        step();
        data_wr = 1'b0;
    endtask

    task automatic tick();
        src_a_en = 1'b1; src_b_tick = 1'b1;
        step();
        src_b_tick = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int highs;
        repeat (3) step();
        // R7 reset values
        chk("R7 count", count_q, 0);
        chk("R7 irq", irq, 0);
        chk("R7 ovf", ovf_pulse, 0);
        chk("R7 pwm", pwm_out, 0);
        rst_n = 1'b1;
        step();
        chk("R7 hold after reset", count_q, 0);

        // R6 load, R1 counting
        load(16'h1234);
        chk("R6 load", count_q, 16'h1234);
        for (int k = 1; k <= 20; k++) begin
            tick();
            chk("R1 count up", count_q, 16'h1234 + k);
        end

        // R3 gating
        src_a_en = 1'b0; src_b_tick = 1'b1;
        repeat (5) step();
        chk("R3 gate low", count_q, 16'h1234 + 20);
        src_a_en = 1'b1; src_b_tick = 1'b0;
        repeat (5) step();
        chk("R3 no tick", count_q, 16'h1234 + 20);

        // R2 wrap
        load(16'hFFF0);
        for (int k = 0; k < 15; k++) tick();
        chk("R1 reach max", count_q, 16'hFFFF);
        chk("R2 no early ovf", ovf_pulse, 0);
        chk("R4 no early irq", irq, 0);
        tick(); novf++;
        chk("R2 reload", count_q, 16'hFFF0);
        chk("R2 ovf pulse", ovf_pulse, 1);
        chk("R4 irq set", irq, 1);
        step();
        chk("R2 ovf one cycle", ovf_pulse, 0);
        repeat (10) step();
        chk("R4 irq held", irq, 1);
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
        chk("R4 irq cleared", irq, 0);

        // R4 clear coinciding with wrap
        load(16'hFFFF);
        irq_clr = 1'b1; tick(); irq_clr = 1'b0; novf++;
        chk("R4 set beats clear", irq, 1);
        chk("R2 reload FFFF", count_q, 16'hFFFF);
        irq_clr = 1'b1; step(); irq_clr = 1'b0;

        // R6 write beats tick and makes no wrap
        src_a_en = 1'b1; src_b_tick = 1'b1; data_wr = 1'b1; data_wdata = 16'h0007;
        step();
        data_wr = 1'b0; src_b_tick = 1'b0;
        chk("R6 write priority", count_q, 16'h0007);
        chk("R6 no ovf", ovf_pulse, 0);
        chk("R6 no irq", irq, 0);
        tick();
        chk("R6 restart count", count_q, 16'h0008);

        // R5 exhaustive duty sweep; every tick wraps
        load(16'hFFFF);
        for (int d = 0; d < 16; d++) begin
            duty_sel = d[3:0];
            highs = 0;
            for (int t = 0; t < 16; t++) begin
                tick(); novf++;
                chk("R2 ovf each tick", ovf_pulse, 1);
                chk("R5 pwm level", pwm_out, ((novf % 16) < d) ? 1 : 0);
                if (pwm_out) highs++;
            end
            chk("R5 high periods", highs, d);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule